// File: doc/BRIEF.md
# Nibble I/O Bus Register Switch

This block sits on the peripheral side of a 4-bit I/O bus. Every bus cycle carries one access: a write (OUT) or a read (IN), a 4-bit module address and, for writes, one data nibble. The block decodes the address and routes the access to one of three kinds of register module. The simple module holds a single 4-bit primary register. The paired module holds a 4-bit primary register and an 8-bit auxiliary register. The indirect module holds a 4-bit index pointer and a bank of 8-bit subport registers.

The auxiliary register and the subport bank are not reached directly. Software first writes the target module's address, as data, to a dedicated switch address. That write arms a one-shot redirect. For the paired module, the next two accesses to it reach the auxiliary register, low nibble first and high nibble second. The redirect then clears. For the indirect module, the next OUT to it loads the pointer. The two accesses after that move the low and then the high nibble of the addressed subport, and the redirect then clears. An unarmed access to the paired module reaches its primary register. An unarmed access to the indirect module reaches its pointer.

Reads are combinational. `io_rdata` shows the selected value during the IN cycle. Any side effect of the access, such as advancing the nibble half, takes place at the clock edge that closes the cycle.

Top module: `nbus_regswitch`

## Requirements
- R1: A synchronous active-high reset clears the simple primary register, the paired primary register, the auxiliary register, the pointer and every subport register to 0, and leaves the switch disarmed with the half select on low.
- R2: Without a redirect, an OUT to the simple module (address 1h) or the paired module (address 2h) stores the nibble in that module's primary register, and an IN returns it.
- R3: An OUT to the switch (address 8h) with data 2h arms the paired module. Its next access reaches the auxiliary register bits 3:0, the access after that reaches bits 7:4, and the switch then disarms.
- R4: An OUT to the switch with data 3h arms the indirect module (address 3h). Its next OUT loads the pointer. The following access reaches bits 3:0 of the subport the pointer names, the next reaches bits 7:4, and the switch then disarms.
- R5: Without a redirect, an OUT to the indirect module writes the pointer, and an IN returns the pointer.
- R6: An IN from the switch returns 2h while the paired module is armed, 3h while the indirect module is armed, and 0h otherwise. A switch OUT with any data other than 2h or 3h disarms the switch.
- R7: An IN from an unmapped address (any address other than 1h, 2h, 3h and 8h) returns 0h. An OUT to an unmapped address changes no register and leaves any pending redirect unchanged.
- R8: While a redirect is pending, accesses to other modules reach their normal registers and neither advance nor clear the pending sequence.
- R9: Each switch OUT that arms a module restarts the half select at low, even in the middle of a sequence.
- R10: `io_rdata` is 0h in every cycle that is not an IN.
- R11: While the indirect module is armed and waiting for its pointer, an IN from it returns the pointer and leaves the sequence waiting for the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_valid | input | 1 | A bus access takes place in this cycle |
| io_wr | input | 1 | 1 = OUT (write), 0 = IN (read) |
| io_addr | input | 4 | Target module address |
| io_wdata | input | 4 | Write nibble |
| io_rdata | output | 4 | Read nibble, valid during an IN cycle |

## Verification
Assertions check these properties on every cycle:
- reads outside an IN cycle return zero;
- unmapped reads return zero;
- an unmapped write leaves the registers alone;
- the sequence leaves the pointer phase after a pointer write;
- the redirect clears after the high nibble.

Only the bench scenarios can show the ordering effects: low nibble before high, re-arming in mid-sequence, and accesses to other modules between the steps of a sequence. A reference model in the bench checks these under random traffic.

// File: rtl/nbus_pkg.sv
package nbus_pkg;
    localparam int NIB = 4;

    typedef enum logic [2:0] {
        DEV_NONE, DEV_SW, DEV_SGL, DEV_DUAL, DEV_IND
    } dev_e;

    typedef enum logic [2:0] {
        T_NONE, T_SW, T_SGL_PRI, T_DUAL_PRI, T_DUAL_AUX, T_IND_PTR, T_IND_SUB
    } tgt_e;

    typedef enum logic [1:0] {
        M_IDLE, M_DUAL, M_IND_PTR, M_IND_DATA
    } mode_e;
endpackage

// File: rtl/nbus_addr_decode.sv
module nbus_addr_decode
    import nbus_pkg::*;
#(
    parameter logic [3:0] A_SW   = 4'h8,
    parameter logic [3:0] A_SGL  = 4'h1,
    parameter logic [3:0] A_DUAL = 4'h2,
    parameter logic [3:0] A_IND  = 4'h3
) (
    input  logic [3:0] addr,
    output dev_e       dev
);
    always_comb begin
        if (addr == A_SW)        dev = DEV_SW;
        else if (addr == A_SGL)  dev = DEV_SGL;
        else if (addr == A_DUAL) dev = DEV_DUAL;
        else if (addr == A_IND)  dev = DEV_IND;
        else                     dev = DEV_NONE;
    end
endmodule

// File: rtl/nbus_seq_ctrl.sv
module nbus_seq_ctrl
    import nbus_pkg::*;
#(
    parameter logic [3:0] A_DUAL = 4'h2,
    parameter logic [3:0] A_IND  = 4'h3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       valid,
    input  logic       wr,
    input  dev_e       dev,
    input  logic [3:0] wdata,
    output tgt_e       tgt,
    output logic       hi,
    output logic [3:0] sw_rdata
);
    typedef struct packed {
        mode_e mode;
        logic  half;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tgt  = T_NONE;
        hi   = 1'b0;
        if (valid) begin
            case (dev)
                DEV_SW: begin
                    tgt = T_SW;
                    if (wr) begin
                        st_d.half = 1'b0;
                        if (wdata == A_DUAL)     st_d.mode = M_DUAL;
                        else if (wdata == A_IND) st_d.mode = M_IND_PTR;
                        else                     st_d.mode = M_IDLE;
                    end
                end
                DEV_SGL: tgt = T_SGL_PRI;
                DEV_DUAL: begin
                    if (st_q.mode == M_DUAL) begin
                        tgt = T_DUAL_AUX;
                        hi  = st_q.half;
                        if (st_q.half) begin
                            st_d.mode = M_IDLE;
                            st_d.half = 1'b0;
                        end else begin
                            st_d.half = 1'b1;
                        end
                    end else begin
                        tgt = T_DUAL_PRI;
                    end
                end
                DEV_IND: begin
                    if (st_q.mode == M_IND_PTR) begin
                        tgt = T_IND_PTR;
                        if (wr) begin
                            st_d.mode = M_IND_DATA;
                            st_d.half = 1'b0;
                        end
                    end else if (st_q.mode == M_IND_DATA) begin
                        tgt = T_IND_SUB;
                        hi  = st_q.half;
                        if (st_q.half) begin
                            st_d.mode = M_IDLE;
                            st_d.half = 1'b0;
                        end else begin
                            st_d.half = 1'b1;
                        end
                    end else begin
                        tgt = T_IND_PTR;
                    end
                end
                default: tgt = T_NONE;
            endcase
        end
        if (rst) begin
            st_d.mode = M_IDLE;
            st_d.half = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_comb begin
        case (st_q.mode)
            M_DUAL:                sw_rdata = A_DUAL;
            M_IND_PTR, M_IND_DATA: sw_rdata = A_IND;
            default:               sw_rdata = 4'h0;
        endcase
    end

    // R3
    aux_hi_disarm_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && dev == DEV_DUAL && st_q.mode == M_DUAL && st_q.half) |=> (st_q.mode == M_IDLE));

    // R4
    ptr_load_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && wr && dev == DEV_IND && st_q.mode == M_IND_PTR) |=> (st_q.mode == M_IND_DATA && !st_q.half));

    // R11
    ptr_read_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && !wr && dev == DEV_IND && st_q.mode == M_IND_PTR) |=> (st_q.mode == M_IND_PTR));

    // R8
    other_mod_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && (dev == DEV_SGL || dev == DEV_NONE)) |=> $stable(st_q));
endmodule

// File: rtl/nbus_reg_bank.sv
module nbus_reg_bank
    import nbus_pkg::*;
#(
    parameter int NUM_SUB = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       valid,
    input  logic       wr,
    input  tgt_e       tgt,
    input  logic       hi,
    input  logic [3:0] wdata,
    input  logic [3:0] sw_rdata,
    output logic [3:0] rdata
);
    localparam int PTR_W  = (NUM_SUB > 1) ? $clog2(NUM_SUB) : 1;
    localparam int BYTE_W = 2 * NIB;

    typedef struct {
        logic [NIB-1:0]    sgl;
        logic [NIB-1:0]    dpri;
        logic [BYTE_W-1:0] aux;
        logic [PTR_W-1:0]  ptr;
        logic [BYTE_W-1:0] sub [NUM_SUB];
    } bank_t;

    bank_t rf_d, rf_q;
    logic [NIB-1:0]    ptr_ext;
    logic [BYTE_W-1:0] sub_sel;

    generate
        if (PTR_W == NIB) begin : g_ptr_full
            assign ptr_ext = rf_q.ptr;
        end else begin : g_ptr_pad
            assign ptr_ext = {{(NIB-PTR_W){1'b0}}, rf_q.ptr};
        end
    endgenerate

    assign sub_sel = rf_q.sub[rf_q.ptr];

    always_comb begin
        rf_d = rf_q;
        if (valid && wr) begin
            case (tgt)
                T_SGL_PRI:  rf_d.sgl  = wdata;
                T_DUAL_PRI: rf_d.dpri = wdata;
                T_DUAL_AUX: begin
                    if (hi) rf_d.aux[BYTE_W-1:NIB] = wdata;
                    else    rf_d.aux[NIB-1:0]      = wdata;
                end
                T_IND_PTR:  rf_d.ptr = wdata[PTR_W-1:0];
                T_IND_SUB: begin
                    if (hi) rf_d.sub[rf_q.ptr][BYTE_W-1:NIB] = wdata;
                    else    rf_d.sub[rf_q.ptr][NIB-1:0]      = wdata;
                end
                default: ;
            endcase
        end
        if (rst) begin
            rf_d.sgl  = '0;
            rf_d.dpri = '0;
            rf_d.aux  = '0;
            rf_d.ptr  = '0;
            for (int i = 0; i < NUM_SUB; i++) rf_d.sub[i] = '0;
        end
    end

    always_ff @(posedge clk) begin
        rf_q <= rf_d;
    end

    always_comb begin
        rdata = 4'h0;
        if (valid && !wr) begin
            case (tgt)
                T_SW:       rdata = sw_rdata;
                T_SGL_PRI:  rdata = rf_q.sgl;
                T_DUAL_PRI: rdata = rf_q.dpri;
                T_DUAL_AUX: rdata = hi ? rf_q.aux[BYTE_W-1:NIB] : rf_q.aux[NIB-1:0];
                T_IND_PTR:  rdata = ptr_ext;
                T_IND_SUB:  rdata = hi ? sub_sel[BYTE_W-1:NIB] : sub_sel[NIB-1:0];
                default:    rdata = 4'h0;
            endcase
        end
    end

    // R10
    idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !(valid && !wr) |-> (rdata == 4'h0));

    // R7
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && !wr && tgt == T_NONE) |-> (rdata == 4'h0));

    // R7
    unmapped_write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && wr && tgt == T_NONE) |=>
            ($stable(rf_q.sgl) && $stable(rf_q.dpri) && $stable(rf_q.aux) && $stable(rf_q.ptr)));

    // R2
    sgl_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && wr && tgt == T_SGL_PRI) |=> (rf_q.sgl == $past(wdata)));
endmodule

// File: rtl/nbus_regswitch.sv
module nbus_regswitch
    import nbus_pkg::*;
#(
    parameter logic [3:0] A_SW    = 4'h8,
    parameter logic [3:0] A_SGL   = 4'h1,
    parameter logic [3:0] A_DUAL  = 4'h2,
    parameter logic [3:0] A_IND   = 4'h3,
    parameter int         NUM_SUB = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       io_valid,
    input  logic       io_wr,
    input  logic [3:0] io_addr,
    input  logic [3:0] io_wdata,
    output logic [3:0] io_rdata
);
    dev_e       dev;
    tgt_e       tgt;
    logic       hi;
    logic [3:0] sw_rdata;

    nbus_addr_decode #(
        .A_SW(A_SW), .A_SGL(A_SGL), .A_DUAL(A_DUAL), .A_IND(A_IND)
    ) u_dec (
        .addr (io_addr),
        .dev  (dev)
    );

    nbus_seq_ctrl #(
        .A_DUAL(A_DUAL), .A_IND(A_IND)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .valid    (io_valid),
        .wr       (io_wr),
        .dev      (dev),
        .wdata    (io_wdata),
        .tgt      (tgt),
        .hi       (hi),
        .sw_rdata (sw_rdata)
    );

    nbus_reg_bank #(
        .NUM_SUB(NUM_SUB)
    ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .valid    (io_valid),
        .wr       (io_wr),
        .tgt      (tgt),
        .hi       (hi),
        .wdata    (io_wdata),
        .sw_rdata (sw_rdata),
        .rdata    (io_rdata)
    );
endmodule

// File: tb/nbus_regswitch_tb.sv
module nbus_regswitch_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       io_valid = 1'b0;
    logic       io_wr = 1'b0;
    logic [3:0] io_addr = 4'h0;
    logic [3:0] io_wdata = 4'h0;
    logic [3:0] io_rdata;

    int total = 0;
    int bad = 0;
    logic done = 1'b0;

    // model state: mode 0 idle, 1 paired armed, 2 wait pointer, 3 subport data
    logic [3:0] m_sgl, m_dpri, m_ptr;
    logic [7:0] m_aux;
    logic [7:0] m_sub [16];
    int         m_mode;
    logic       m_half;

    always #5 clk = ~clk;

    nbus_regswitch dut_i (
        .clk(clk), .rst(rst), .io_valid(io_valid), .io_wr(io_wr),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata)
    );

    task automatic model_reset();
        m_sgl = 0; m_dpri = 0; m_ptr = 0; m_aux = 0;
        for (int i = 0; i < 16; i++) m_sub[i] = 0;
        m_mode = 0; m_half = 0;
    endtask

    function automatic logic [3:0] model_read(logic w, logic [3:0] a);
        if (w) return 4'h0;
        case (a)
            4'h8: return (m_mode == 1) ? 4'h2 : (m_mode >= 2) ? 4'h3 : 4'h0;
            4'h1: return m_sgl;
            4'h2: return (m_mode == 1) ? (m_half ? m_aux[7:4] : m_aux[3:0]) : m_dpri;
            4'h3: return (m_mode == 3) ? (m_half ? m_sub[m_ptr][7:4] : m_sub[m_ptr][3:0]) : m_ptr;
            default: return 4'h0;
        endcase
    endfunction

    task automatic model_update(logic w, logic [3:0] a, logic [3:0] d);
        case (a)
            4'h8: if (w) begin
                m_half = 0;
                m_mode = (d == 4'h2) ? 1 : (d == 4'h3) ? 2 : 0;
            end
            4'h1: if (w) m_sgl = d;
            4'h2: if (m_mode == 1) begin
                if (w) begin
                    if (m_half) m_aux[7:4] = d; else m_aux[3:0] = d;
                end
                if (m_half) begin m_mode = 0; m_half = 0; end else m_half = 1;
            end else if (w) m_dpri = d;
            4'h3: if (m_mode == 3) begin
                if (w) begin
                    if (m_half) m_sub[m_ptr][7:4] = d; else m_sub[m_ptr][3:0] = d;
                end
                if (m_half) begin m_mode = 0; m_half = 0; end else m_half = 1;
            end else if (w) begin
                m_ptr = d;
                if (m_mode == 2) begin m_mode = 3; m_half = 0; end
            end
            default: ;
        endcase
    endtask

    task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one bus cycle; checks rdata against the model and then advances the model
    task automatic acc(string tag, logic w, logic [3:0] a, logic [3:0] d);
        logic [3:0] e;
        @(negedge clk);
        io_valid = 1'b1; io_wr = w; io_addr = a; io_wdata = d;
        e = model_read(w, a);
        #1 chk(tag, io_rdata, e);
        @(posedge clk);
        model_update(w, a, d);
        #1 io_valid = 1'b0;
    endtask

    // directed read with a fixed expected value from the requirements
    task automatic rd_exp(string tag, logic [3:0] a, logic [3:0] exp);
        @(negedge clk);
        io_valid = 1'b1; io_wr = 1'b0; io_addr = a; io_wdata = 4'h0;
        #1 chk(tag, io_rdata, exp);
        chk({tag, "_model"}, exp, model_read(1'b0, a));
        @(posedge clk);
        model_update(1'b0, a, 4'h0);
        #1 io_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; io_valid = 1'b0;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        model_reset();
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED1234));
        model_reset();
        do_reset();

        // R1: reset state
        rd_exp("R1_sgl", 4'h1, 4'h0);
        rd_exp("R1_dpri", 4'h2, 4'h0);
        rd_exp("R1_ptr", 4'h3, 4'h0);
        rd_exp("R1_sw", 4'h8, 4'h0);
        @(negedge clk); #1 chk("R10_idle", io_rdata, 4'h0);

        // R2
        acc("R2_w", 1, 4'h1, 4'hA);  rd_exp("R2_sgl", 4'h1, 4'hA);
        acc("R2_w", 1, 4'h2, 4'h5);  rd_exp("R2_dpri", 4'h2, 4'h5);

        // R3: auxiliary byte, low then high
        acc("R3_arm", 1, 4'h8, 4'h2);
        rd_exp("R6_dual", 4'h8, 4'h2);
        acc("R3_lo", 1, 4'h2, 4'hC);
        acc("R8_mid", 1, 4'h1, 4'h7);          // R8: other module mid-sequence
        rd_exp("R8_sw", 4'h8, 4'h2);
        acc("R3_hi", 1, 4'h2, 4'h3);
        rd_exp("R3_disarm", 4'h8, 4'h0);
        rd_exp("R3_pri", 4'h2, 4'h5);
        acc("R3_arm2", 1, 4'h8, 4'h2);
        rd_exp("R3_auxlo", 4'h2, 4'hC);
        rd_exp("R3_auxhi", 4'h2, 4'h3);

        // R9: re-arm mid-sequence restarts at low
        acc("R9_arm", 1, 4'h8, 4'h2);
        acc("R9_lo", 1, 4'h2, 4'h9);
        acc("R9_rearm", 1, 4'h8, 4'h2);
        rd_exp("R9_lo_again", 4'h2, 4'h9);
        rd_exp("R9_hi", 4'h2, 4'h3);

        // R4 / R11: indirect subport byte
        acc("R4_arm", 1, 4'h8, 4'h3);
        rd_exp("R6_ind", 4'h8, 4'h3);
        rd_exp("R11_ptr", 4'h3, 4'h0);
        acc("R4_ptr", 1, 4'h3, 4'h6);
        acc("R7_unmapped_w", 1, 4'hB, 4'hF);   // R7: ignored mid-sequence
        acc("R4_lo", 1, 4'h3, 4'hE);
        acc("R4_hi", 1, 4'h3, 4'h1);
        rd_exp("R5_ptr", 4'h3, 4'h6);
        acc("R4_arm2", 1, 4'h8, 4'h3);
        acc("R4_ptr2", 1, 4'h3, 4'h6);
        rd_exp("R4_rdlo", 4'h3, 4'hE);
        rd_exp("R4_rdhi", 4'h3, 4'h1);
        rd_exp("R4_done", 4'h8, 4'h0);

        // R5: unarmed pointer access
        acc("R5_w", 1, 4'h3, 4'hD);
        rd_exp("R5_rd", 4'h3, 4'hD);

        // R6: switch write with other data disarms
        acc("R6_arm", 1, 4'h8, 4'h2);
        acc("R6_other", 1, 4'h8, 4'h1);
        rd_exp("R6_off", 4'h8, 4'h0);
        rd_exp("R6_pri", 4'h2, 4'h5);

        // R7: unmapped
        rd_exp("R7_rd", 4'h0, 4'h0);
        rd_exp("R7_rd", 4'hF, 4'h0);
        acc("R7_w", 1, 4'h4, 4'hF);
        rd_exp("R7_sgl", 4'h1, 4'h7);

        // random traffic against the model
        for (int n = 0; n < 4000; n++) begin
            logic [3:0] a, d;
            logic w;
            int pick;
            pick = $urandom_range(0, 9);
            case (pick)
                0, 1: a = 4'h8;
                2:    a = 4'h1;
                3, 4: a = 4'h2;
                5, 6: a = 4'h3;
                7:    a = 4'($urandom_range(0, 15));
                default: a = (pick == 8) ? 4'h2 : 4'h3;
            endcase
            w = 1'($urandom_range(0, 1));
            d = 4'($urandom_range(0, 15));
            if (a == 4'h8 && $urandom_range(0, 3) != 0) d = $urandom_range(0, 1) ? 4'h2 : 4'h3;
            acc("R3_R4_R8_rand", w, a, d);
            if (n == 2000) begin
                do_reset();
                rd_exp("R1_mid_sw", 4'h8, 4'h0);
                rd_exp("R1_mid_ptr", 4'h3, 4'h0);
            end
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule